// File: doc/BRIEF.md
# Burst Flash Clock and Strobe Generator

This block produces the external clock for a synchronous burst flash port. It also retimes the address-valid and burst-advance strobes that a bus controller hands it. It runs from a reference clock at twice the internal bus clock. One bus-clock period therefore spans two reference cycles ("halves"), so every output changes on an ordinary register edge. The external clock runs at the bus rate divided by 1, 2, 3 or 4. It either runs freely or is gated to flash accesses, and in gated mode it sits low while idle.

Configuration is written through a one-cycle write strobe into a pending register. The pending values become active only at an idle point. In gated mode that is whenever the clock is stopped. In either mode it is also any period boundary with no access open. A period that has begun is therefore never reshaped. In gated mode a start indication launches the clock with a rising edge on the next reference edge. An end indication lets the current period finish, including its whole low phase, before the clock parks low. A one-cycle data-path enable marks every rising edge of the external clock. The strobes come out either one reference cycle after their request or one half bus period later than that.

Top module: `bflash_clkgen`

## Requirements
- R1: With active ratio code k (0..3), the external clock period is 2·(k+1) reference cycles (bus clock, 1/2, 1/3, 1/4).
- R2: The high time per period is 1, 2, 2 and 4 reference cycles for codes 0, 1, 2 and 3 respectively. Code 2 is therefore high one third of its period.
- R3: After reset the active and pending settings are ratio code 3, gated mode, delayed strobes, and all outputs are low.
- R4: With the gated bit at 0, the clock toggles continuously with no access open.
- R5: With the gated bit at 1 and the clock stopped, the clock stays low. An `acc_start` pulse makes it high on the very next reference edge.
- R6: After `acc_end` in gated mode, the clock completes its current period, including the full low phase, and then stays low.
- R7: A configuration write takes effect only at an idle point: the clock is stopped, or a period ends with no access open. A write during an open access leaves the running ratio unchanged.
- R8: `edge_en` is high for exactly one reference cycle, the cycle in which `bf_clk` has just gone from 0 to 1.
- R9: With the early bit at 1, each strobe output equals its request one reference cycle earlier. With the early bit at 0, it equals the request two reference cycles earlier.
- R10: If `acc_start` and `acc_end` are high in the same cycle, the start wins and the access stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the bus clock frequency |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the pending configuration |
| cfg_div | input | 2 | Ratio code: 0 = /1, 1 = /2, 2 = /3, 3 = /4 |
| cfg_gate | input | 1 | 1 = clock only during accesses, 0 = free-running |
| cfg_early | input | 1 | 1 = strobes without the half bus period delay |
| acc_start | input | 1 | One-cycle access-start indication |
| acc_end | input | 1 | One-cycle access-end indication |
| adv_req | input | 1 | Address-valid request from the controller |
| baa_req | input | 1 | Burst-advance request from the controller |
| bf_clk | output | 1 | External burst flash clock |
| adv_o | output | 1 | Retimed address-valid strobe |
| baa_o | output | 1 | Retimed burst-advance strobe |
| edge_en | output | 1 | One-cycle enable at each rising edge of `bf_clk` |

## Verification
The hardest case to reach is a configuration write that lands while an access is open. The old ratio must persist until the access ends and the clock has parked, and only the next access may use the new ratio. The stimulus first opens an access at the reset ratio, writes ratio code 0 mid-access and measures the period again. It then closes the access, waits for the clock to park and opens a new one to measure the new period. A long random phase follows. It mixes writes, start and end pulses that overlap with period boundaries, and strobe patterns, and a behavioural reference model is compared against the outputs every cycle.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  // High time in reference cycles for a ratio code: n = code+1 halves-pairs.
  // Odd ratios above one are shortened to n-1 so the duty stays below half.
  function automatic int unsigned high_len(input int unsigned code);
    int unsigned n;
    n = code + 1;
    if (n > 1 && (n % 2) == 1) return n - 1;
    return n;
  endfunction

endpackage

// File: rtl/bfc_cfg_shadow.sv
module bfc_cfg_shadow #(
  parameter int            RW        = 2,
  parameter logic [RW-1:0] RST_RATIO = '1,
  parameter logic          RST_GATED = 1'b1,
  parameter logic          RST_EARLY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [RW-1:0] wr_ratio,
  input  logic          wr_gated,
  input  logic          wr_early,
  input  logic          apply,
  output logic [RW-1:0] cur_ratio,
  output logic          cur_gated,
  output logic          cur_early,
  output logic [RW-1:0] nxt_ratio,
  output logic          nxt_gated,
  output logic          nxt_early
);

  logic [RW-1:0] pend_ratio;
  logic          pend_gated;
  logic          pend_early;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ratio <= RST_RATIO;
      pend_gated <= RST_GATED;
      pend_early <= RST_EARLY;
      cur_ratio  <= RST_RATIO;
      cur_gated  <= RST_GATED;
      cur_early  <= RST_EARLY;
    end else begin
      if (wr) begin
        pend_ratio <= wr_ratio;
        pend_gated <= wr_gated;
        pend_early <= wr_early;
      end
      if (apply) begin
        cur_ratio <= pend_ratio;
        cur_gated <= pend_gated;
        cur_early <= pend_early;
      end
    end
  end

  // Settings in force for the period that starts at this edge.
  always_comb begin
    nxt_ratio = apply ? pend_ratio : cur_ratio;
    nxt_gated = apply ? pend_gated : cur_gated;
    nxt_early = apply ? pend_early : cur_early;
  end

endmodule

// File: rtl/bfc_phase_gen.sv
module bfc_phase_gen
  import bfc_pkg::*;
#(
  parameter int RW = 2,
  parameter int PW = RW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] cur_ratio,
  input  logic [RW-1:0] nxt_ratio,
  input  logic          nxt_gated,
  input  logic          acc_start,
  input  logic          acc_end,
  output logic          idle_pt,
  output logic          bf_clk,
  output logic          edge_en
);

  logic          run_q, busy_q, clk_q, edge_q;
  logic [PW-1:0] ph_q;
  logic          run_d, busy_d, clk_d;
  logic [PW-1:0] ph_d;
  logic [PW-1:0] last_ph;
  logic [PW:0]   hi_n;
  logic          wrap;

  always_comb begin
    last_ph = {cur_ratio, 1'b1};
    wrap    = run_q && (ph_q == last_ph);
    idle_pt = !run_q || (wrap && !busy_q);
    busy_d  = acc_start || (busy_q && !acc_end);
    run_d   = run_q;
    ph_d    = ph_q + 1'b1;
    if (!run_q) begin
      ph_d  = '0;
      run_d = !nxt_gated || acc_start;
    end else if (wrap) begin
      ph_d  = '0;
      run_d = !(nxt_gated && !busy_d);
    end
    hi_n  = (PW+1)'(high_len(32'(nxt_ratio)));
    clk_d = run_d && ({1'b0, ph_d} < hi_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      ph_q   <= '0;
      clk_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      busy_q <= busy_d;
      ph_q   <= ph_d;
      clk_q  <= clk_d;
      edge_q <= clk_d && !clk_q;
    end
  end

  assign bf_clk  = clk_q;
  assign edge_en = edge_q;

  // R5
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && nxt_gated && acc_start) |=> clk_q);

  // R8
  edge_only_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    edge_q |-> (clk_q && !$past(clk_q)));

  // R8
  rise_has_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_q) |-> edge_q);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !idle_pt) |=> $stable(cur_ratio));

  // R6
  full_period_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> run_q);

endmodule

// File: rtl/bfc_strobe_dly.sv
module bfc_strobe_dly #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          early,
  input  logic [NS-1:0] req,
  output logic [NS-1:0] strb
);

  for (genvar i = 0; i < NS; i++) begin : g_lane
    logic d1_q, o_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        d1_q <= 1'b0;
        o_q  <= 1'b0;
      end else begin
        d1_q <= req[i];
        o_q  <= early ? req[i] : d1_q;
      end
    end

    assign strb[i] = o_q;

    // R9
    early_path_chk: assert property (@(posedge clk) disable iff (rst)
      early |=> (o_q == $past(req[i])));

    // R9
    late_path_chk: assert property (@(posedge clk) disable iff (rst)
      (!early && !$past(rst)) |=> (o_q == $past(req[i], 2)));
  end

endmodule

// File: rtl/bflash_clkgen.sv
module bflash_clkgen #(
  parameter int RW = 2,
  parameter int PW = RW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [RW-1:0] cfg_div,
  input  logic          cfg_gate,
  input  logic          cfg_early,
  input  logic          acc_start,
  input  logic          acc_end,
  input  logic          adv_req,
  input  logic          baa_req,
  output logic          bf_clk,
  output logic          adv_o,
  output logic          baa_o,
  output logic          edge_en
);

  localparam int NS = 2;

  logic [RW-1:0] cur_ratio, nxt_ratio;
  logic          cur_gated, nxt_gated;
  logic          cur_early, nxt_early;
  logic          idle_pt;
  logic [NS-1:0] strb;

  bfc_cfg_shadow #(.RW(RW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .wr_ratio  (cfg_div),
    .wr_gated  (cfg_gate),
    .wr_early  (cfg_early),
    .apply     (idle_pt),
    .cur_ratio (cur_ratio),
    .cur_gated (cur_gated),
    .cur_early (cur_early),
    .nxt_ratio (nxt_ratio),
    .nxt_gated (nxt_gated),
    .nxt_early (nxt_early)
  );

  bfc_phase_gen #(.RW(RW), .PW(PW)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .cur_ratio (cur_ratio),
    .nxt_ratio (nxt_ratio),
    .nxt_gated (nxt_gated),
    .acc_start (acc_start),
    .acc_end   (acc_end),
    .idle_pt   (idle_pt),
    .bf_clk    (bf_clk),
    .edge_en   (edge_en)
  );

  bfc_strobe_dly #(.NS(NS)) u_strb (
    .clk   (clk),
    .rst   (rst),
    .early (cur_early),
    .req   ({baa_req, adv_req}),
    .strb  (strb)
  );

  assign adv_o = strb[0];
  assign baa_o = strb[1];

  // R3: right after reset release the clock is parked low
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bf_clk && !adv_o && !baa_o && !edge_en));

  logic unused_cfg;
  assign unused_cfg = cur_gated ^ nxt_early;

endmodule

// File: tb/bflash_clkgen_tb.sv
module bflash_clkgen_tb;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cfg_wr = 0, cfg_gate = 0, cfg_early = 0;
  logic [1:0] cfg_div = 0;
  logic       acc_start = 0, acc_end = 0, adv_req = 0, baa_req = 0;
  logic       bf_clk, adv_o, baa_o, edge_en;

  always #5 clk = ~clk;

  bflash_clkgen u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_gate(cfg_gate), .cfg_early(cfg_early), .acc_start(acc_start),
    .acc_end(acc_end), .adv_req(adv_req), .baa_req(baa_req),
    .bf_clk(bf_clk), .adv_o(adv_o), .baa_o(baa_o), .edge_en(edge_en)
  );

  int vec = 0, bad = 0;
  bit done = 0;
  int smp = 0;

  // behavioural reference state
  int m_ratio = 3, p_ratio = 3;
  bit m_gated = 1, p_gated = 1, m_early = 0, p_early = 0;
  bit m_run = 0, m_busy = 0, m_clk = 0, m_edge = 0;
  int m_ph = 0;
  bit ma_1 = 0, mb_1 = 0, ma_o = 0, mb_o = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hi_of(input int code);
    return (code == 2) ? 2 : code + 1;
  endfunction

  task automatic model_step();
    bit wrap, bnd, nb, oldclk;
    if (rst) begin
      m_ratio = 3; p_ratio = 3; m_gated = 1; p_gated = 1;
      m_early = 0; p_early = 0; m_run = 0; m_busy = 0;
      m_clk = 0; m_edge = 0; m_ph = 0;
      ma_1 = 0; mb_1 = 0; ma_o = 0; mb_o = 0;
    end else begin
      oldclk = m_clk;
      if (m_early) begin ma_o = adv_req; mb_o = baa_req; end
      else begin ma_o = ma_1; mb_o = mb_1; end
      ma_1 = adv_req; mb_1 = baa_req;
      wrap = m_run && (m_ph == 2 * m_ratio + 1);
      bnd  = !m_run || (wrap && !m_busy);
      if (bnd) begin m_ratio = p_ratio; m_gated = p_gated; m_early = p_early; end
      if (cfg_wr) begin p_ratio = int'(cfg_div); p_gated = cfg_gate; p_early = cfg_early; end
      nb = acc_start || (m_busy && !acc_end);
      if (!m_run) begin m_ph = 0; m_run = !m_gated || acc_start; end
      else if (wrap) begin m_ph = 0; m_run = !(m_gated && !nb); end
      else m_ph++;
      m_busy = nb;
      m_clk  = m_run && (m_ph < hi_of(m_ratio));
      m_edge = m_clk && !oldclk;
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    chk(bf_clk == m_clk, "R1 bf_clk vs model", int'(bf_clk), int'(m_clk));
    chk(edge_en == m_edge, "R8 edge_en vs model", int'(edge_en), int'(m_edge));
    chk(adv_o == ma_o, "R9 adv_o vs model", int'(adv_o), int'(ma_o));
    chk(baa_o == mb_o, "R9 baa_o vs model", int'(baa_o), int'(mb_o));
    smp = int'(bf_clk);
  endtask

  task automatic write_cfg(input int d, input bit g, input bit e);
    cfg_div = 2'(d); cfg_gate = g; cfg_early = e; cfg_wr = 1;
    cyc();
    cfg_wr = 0;
  endtask

  task automatic measure(output int h, output int p);
    int prev, g, l;
    g = 0;
    do begin prev = smp; cyc(); g++; end while (!(prev == 0 && smp == 1) && g < 64);
    h = 0; l = 0;
    while (smp == 1 && h < 64) begin h++; cyc(); end
    while (smp == 0 && l < 64) begin l++; cyc(); end
    p = h + l;
  endtask

  task automatic count_high(input int n, output int hs);
    hs = 0;
    for (int i = 0; i < n; i++) begin cyc(); hs += smp; end
  endtask

  initial begin
    int h, p, hs;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R3 reset state
    chk(bf_clk == 0, "R3 clock low after reset", int'(bf_clk), 0);
    chk(adv_o == 0 && baa_o == 0, "R3 strobes low after reset", int'(adv_o | baa_o), 0);
    // R5 gated idle stays low
    count_high(10, hs);
    chk(hs == 0, "R5 gated idle clock low", hs, 0);
    // R5 first edge right after start
    acc_start = 1; cyc(); acc_start = 0;
    chk(smp == 1, "R5 rising edge after start", smp, 1);
    // R3 default ratio is one quarter
    measure(h, p);
    chk(p == 8, "R3 default period", p, 8);
    chk(h == 4, "R2 quarter high time", h, 4);
    // R7 write during access keeps running ratio
    write_cfg(0, 1, 0);
    measure(h, p);
    chk(p == 8, "R7 ratio held during access", p, 8);
    // R6 stop after a full period
    acc_end = 1; cyc(); acc_end = 0;
    repeat (8) cyc();
    count_high(16, hs);
    chk(hs == 0, "R6 clock parked after end", hs, 0);
    // R7 new ratio used on the next access
    acc_start = 1; cyc(); acc_start = 0;
    measure(h, p);
    chk(p == 2, "R7 new ratio after idle", p, 2);
    chk(h == 1, "R2 full-rate high time", h, 1);
    acc_end = 1; cyc(); acc_end = 0;
    repeat (6) cyc();
    // R10 start wins over end
    acc_start = 1; acc_end = 1; cyc(); acc_start = 0; acc_end = 0;
    count_high(20, hs);
    chk(hs == 10, "R10 access stays open", hs, 10);
    acc_end = 1; cyc(); acc_end = 0;
    repeat (6) cyc();
    // R1 R2 R4 free-running for each ratio
    for (int k = 0; k < 4; k++) begin
      write_cfg(k, 0, 0);
      repeat (12) cyc();
      measure(h, p);
      chk(p == 2 * (k + 1), "R1 free-run period", p, 2 * (k + 1));
      chk(h == hi_of(k), "R2 free-run high time", h, hi_of(k));
      count_high(16, hs);
      chk(hs > 0 && hs < 16, "R4 toggles without access", hs, 8);
    end
    // R9 strobe latency, early
    write_cfg(1, 0, 1);
    repeat (12) cyc();
    adv_req = 1; cyc(); adv_req = 0;
    chk(adv_o == 1, "R9 early one-cycle latency", int'(adv_o), 1);
    cyc();
    chk(adv_o == 0, "R9 early pulse width", int'(adv_o), 0);
    // R9 strobe latency, delayed
    write_cfg(1, 0, 0);
    repeat (12) cyc();
    baa_req = 1; cyc(); baa_req = 0;
    chk(baa_o == 0, "R9 delayed not yet out", int'(baa_o), 0);
    cyc();
    chk(baa_o == 1, "R9 delayed two-cycle latency", int'(baa_o), 1);
    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      cfg_wr    = ($urandom_range(0, 39) == 0);
      cfg_div   = 2'($urandom_range(0, 3));
      cfg_gate  = 1'($urandom_range(0, 1));
      cfg_early = 1'($urandom_range(0, 1));
      acc_start = ($urandom_range(0, 19) == 0);
      acc_end   = ($urandom_range(0, 14) == 0);
      adv_req   = 1'($urandom_range(0, 1));
      baa_req   = 1'($urandom_range(0, 1));
      cyc();
    end
    cfg_wr = 0; acc_start = 0; acc_end = 0;
    repeat (4) cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule